// File: doc/BRIEF.md
# UART Receive Buffer with Trigger Interrupt

This block holds characters on their way from a UART receive path to a register-read port. Each stored entry carries an 8-bit character and four tag bits: framing error, parity error, break, and overrun. The entries sit in a circular store. A read position and a fill count keep track of them. The block drives empty, full and ready-to-accept flags. It also drives a receive interrupt request, which follows a fill trigger level.

A mode input picks the store size. In multi-entry mode it holds 16 entries. In single-entry mode it acts as one holding register. Any change of the mode input flushes the store.

The receive side has two push strobes. One pushes an ordinary character with its error bits. The other pushes a break-tagged word. The read side pops the oldest entry. The pop also copies that entry's tag bits into a sticky status word, which a clear strobe resets.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset the block is in single-entry mode. Empty is 1, full is 0, ready-to-accept is 1, the interrupt is 0 and the status is 0.
- R2: The depth is 16 while `fifo_mode` is 1 and 1 while it is 0. `rx_full` is 1 exactly when the count equals the depth. `rx_empty` is 1 exactly when the count is 0. `can_accept` is 1 exactly when the count is below the depth.
- R3: A push stores its entry at slot (read position + count) mod depth. Pops return entries in push order, data on `pop_data` and tag on `pop_tag`, including across the wrap of the store.
- R4: A push that arrives while the count equals the depth is dropped, and the stored entries are not changed. The next accepted push stores tag bit 3 (overrun) set. That bit is then cleared for later pushes.
- R5: A pop while the count is 0 presents the entry at the read position. The count stays 0 and the read position does not move.
- R6: `rx_irq` sets when an accepted push makes the count equal to the trigger level (1). It clears when a pop leaves the count one below the trigger level.
- R7: A cycle in which `fifo_mode` differs from the current mode switches the mode. It also sets the count and read position to 0, clears the interrupt and clears the pending overrun. A push or pop in that cycle is ignored.
- R8: `brk_push` stores a break word: data 0 with tag bit 2 set, bits 1:0 clear, and bit 3 set as described in R4. When `push` is high in the same cycle, `brk_push` wins.
- R9: An accepted pop loads `rx_status` with the popped tag. The bits are 0 framing, 1 parity, 2 break and 3 overrun. `stat_clr` zeroes the status, except in a cycle with an accepted pop, where the pop wins.
- R10: A push and a pop in the same cycle both take effect. The push is judged against the count before the pop, so a push at full is still dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_mode | input | 1 | 1 selects 16-entry mode, 0 selects single-entry mode |
| push | input | 1 | Push a received character |
| push_data | input | 8 | Received character |
| push_frm | input | 1 | Framing error tag of the character |
| push_par | input | 1 | Parity error tag of the character |
| brk_push | input | 1 | Push a break word |
| pop | input | 1 | Pop the oldest entry |
| stat_clr | input | 1 | Clear the receive status |
| pop_data | output | 8 | Character at the read position |
| pop_tag | output | 4 | Tag at the read position |
| rx_empty | output | 1 | Count is zero |
| rx_full | output | 1 | Count equals depth |
| can_accept | output | 1 | Count below depth |
| rx_irq | output | 1 | Receive interrupt request |
| rx_status | output | 4 | Tag of the last popped entry |

## Verification
The hardest state to reach is an overrun tag that arrives at the status port. Getting there takes four steps in order:
1. Fill the store.
2. Push once more, so that push is dropped.
3. Pop to make room.
4. Push again, then drain the store down to that entry.

Directed sequences walk through these steps in both modes, with the 16-entry pass placed after a wrap of the read position. Long random runs then mix pushes, breaks, pops, status clears and rare mode switches. In those runs the store often sits at full while a push and a pop land together.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  parameter int TRIG  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_mode,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          push_frm,
  input  logic          push_par,
  input  logic          brk_push,
  input  logic          pop,
  input  logic          stat_clr,
  output logic [DW-1:0] pop_data,
  output logic [3:0]    pop_tag,
  output logic          rx_empty,
  output logic          rx_full,
  output logic          can_accept,
  output logic          rx_irq,
  output logic [3:0]    rx_status
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int EW = DW + 4;

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_q;
  logic [CW-1:0] cnt_q;
  logic          mode_q, ovr_q;

  logic          chg, wr_req, wr_ok, rd_ok, rd_adv;
  logic [CW-1:0] depth_c, cnt_nxt;
  logic [AW-1:0] mask, wr_slot;
  logic [EW-1:0] wr_word;

  assign chg     = fifo_mode != mode_q;
  assign depth_c = mode_q ? CW'(DEPTH) : CW'(1);
  assign mask    = mode_q ? AW'(DEPTH - 1) : '0;
  assign wr_req  = push | brk_push;
  assign wr_ok   = wr_req & ~chg & (cnt_q < depth_c);
  assign rd_ok   = pop & ~chg;
  assign rd_adv  = rd_ok & (cnt_q != '0);
  assign cnt_nxt = cnt_q + CW'(wr_ok) - CW'(rd_adv);
  assign wr_slot = AW'(rd_q + AW'(cnt_q)) & mask;
  assign wr_word = brk_push ? {ovr_q, 3'b100, DW'(0)}
                            : {ovr_q, 1'b0, push_par, push_frm, push_data};

  assign {pop_tag, pop_data} = mem[rd_q];
  assign rx_empty   = cnt_q == '0;
  assign rx_full    = cnt_q == depth_c;
  assign can_accept = cnt_q < depth_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_ok) begin
      mem[wr_slot] <= wr_word;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q      <= '0;
      cnt_q     <= '0;
      mode_q    <= 1'b0;
      ovr_q     <= 1'b0;
      rx_irq    <= 1'b0;
      rx_status <= '0;
    end else if (chg) begin
      mode_q <= fifo_mode;
      rd_q   <= '0;
      cnt_q  <= '0;
      ovr_q  <= 1'b0;
      rx_irq <= 1'b0;
      if (stat_clr) rx_status <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      if (rd_adv) rd_q <= AW'(rd_q + 1'b1) & mask;
      if (wr_ok) ovr_q <= 1'b0;
      else if (wr_req) ovr_q <= 1'b1;
      if (wr_ok && int'(cnt_nxt) == TRIG) rx_irq <= 1'b1;
      else if (rd_ok && int'(cnt_nxt) + 1 == TRIG) rx_irq <= 1'b0;
      if (rd_ok) rx_status <= pop_tag;
      else if (stat_clr) rx_status <= '0;
    end
  end

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= depth_c);
  a_r2_single_depth: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> cnt_q <= CW'(1));
  a_r4_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && rx_full && !pop && !chg) |=> rx_full && $stable(rd_q));
  a_r5_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && rx_empty && !wr_req && !chg) |=> rx_empty && $stable(rd_q));
  a_r6_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> !rx_empty);
  a_r7_flush: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> rx_empty && !rx_irq && rd_q == '0);
endmodule

// File: tb/tb_uart_rx_fifo.sv
module tb_uart_rx_fifo;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n, fifo_mode, push, push_frm, push_par, brk_push, pop, stat_clr;
  logic [7:0] push_data, pop_data;
  logic [3:0] pop_tag, rx_status;
  logic rx_empty, rx_full, can_accept, rx_irq;

  int checks = 0;
  int fails  = 0;

  logic [11:0] mm [16];
  int  mrd, mcnt;
  logic mmode, movr, mirq;
  logic [3:0] mstat;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_fifo dut (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .push(push),
    .push_data(push_data), .push_frm(push_frm), .push_par(push_par),
    .brk_push(brk_push), .pop(pop), .stat_clr(stat_clr),
    .pop_data(pop_data), .pop_tag(pop_tag), .rx_empty(rx_empty),
    .rx_full(rx_full), .can_accept(can_accept), .rx_irq(rx_irq),
    .rx_status(rx_status)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int depth_of(logic md);
    return md ? 16 : 1;
  endfunction

  task automatic model_step(logic pu, logic [7:0] d, logic f, logic p, logic b,
                            logic po, logic clr, logic md);
    int dep, c0, r0, nc;
    logic acc;
    if (md != mmode) begin
      mmode = md; mcnt = 0; mrd = 0; mirq = 0; movr = 0;
      if (clr) mstat = 0;
      return;
    end
    dep = depth_of(mmode);
    c0 = mcnt; r0 = mrd;
    acc = (pu || b) && c0 < dep;
    nc = c0;
    if (po) begin
      mstat = mm[r0][11:8];
      if (c0 > 0) begin mrd = (r0 + 1) % dep; nc--; end
    end else if (clr) mstat = 0;
    if (acc) begin
      mm[(r0 + c0) % dep] = b ? {movr, 3'b100, 8'h00} : {movr, 1'b0, p, f, d};
      movr = 0; nc++;
    end else if (pu || b) movr = 1;
    mcnt = nc;
    if (acc && nc == 1) mirq = 1;
    else if (po && nc + 1 == 1) mirq = 0;
  endtask

  task automatic step(string req, logic pu, logic [7:0] d, logic f, logic p,
                      logic b, logic po, logic clr, logic md);
    @(negedge clk);
    push = pu; push_data = d; push_frm = f; push_par = p; brk_push = b;
    pop = po; stat_clr = clr; fifo_mode = md;
    #1;
    if (po && md == mmode) begin
      chk(req, "pop_data", pop_data, mm[mrd][7:0]);
      chk(req, "pop_tag", pop_tag, mm[mrd][11:8]);
    end
    @(posedge clk);
    model_step(pu, d, f, p, b, po, clr, md);
    #1;
    chk(req, "rx_empty", rx_empty, mcnt == 0);
    chk(req, "rx_full", rx_full, mcnt == depth_of(mmode));
    chk(req, "can_accept", can_accept, mcnt < depth_of(mmode));
    chk(req, "rx_irq", rx_irq, mirq);
    chk(req, "rx_status", rx_status, mstat);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; fifo_mode = 0; push = 0; push_data = 0; push_frm = 0;
    push_par = 0; brk_push = 0; pop = 0; stat_clr = 0;
    for (int i = 0; i < 16; i++) mm[i] = '0;
    mrd = 0; mcnt = 0; mmode = 0; movr = 0; mirq = 0; mstat = 0;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    chk("R1", "rx_empty", rx_empty, 1);
    chk("R1", "rx_full", rx_full, 0);
    chk("R1", "can_accept", can_accept, 1);
    chk("R1", "rx_irq", rx_irq, 0);
    chk("R1", "rx_status", rx_status, 0);

    // single-entry mode
    step("R2", 1, 8'hA5, 0, 1, 0, 0, 0, 0);
    chk("R2", "single full", rx_full, 1);
    step("R4", 1, 8'h3C, 1, 0, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R4", "kept data", mm[0][7:0], 8'hA5);
    step("R4", 1, 8'h11, 0, 0, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R9", "overrun status", rx_status, 4'h8);
    step("R9", 0, 0, 0, 0, 0, 0, 1, 0);
    step("R5", 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R5", "still empty", rx_empty, 1);

    // switch to 16-entry mode, push in the switch cycle is ignored
    step("R7", 1, 8'h77, 0, 0, 0, 0, 0, 1);
    chk("R7", "flushed", rx_empty, 1);
    for (int i = 0; i < 16; i++) step("R3", 1, 8'(i * 7 + 1), i[0], i[1], 0, 0, 0, 1);
    chk("R2", "full at 16", rx_full, 1);
    step("R4", 1, 8'hEE, 0, 0, 0, 0, 0, 1);
    step("R10", 1, 8'hDD, 0, 0, 0, 1, 0, 1);
    for (int i = 0; i < 5; i++) step("R3", 0, 0, 0, 0, 0, 1, 0, 1);
    for (int i = 0; i < 5; i++) step("R4", 1, 8'(8'h80 + i), 0, 0, 0, 0, 0, 1);
    step("R10", 1, 8'h55, 1, 1, 0, 1, 0, 1);
    for (int i = 0; i < 16; i++) step("R3", 0, 0, 0, 0, 0, 1, 0, 1);
    step("R6", 1, 8'h42, 0, 0, 1, 0, 0, 1);
    chk("R6", "irq on first push", rx_irq, 1);
    step("R8", 0, 0, 0, 0, 0, 1, 0, 1);
    chk("R8", "break status", rx_status, 4'h4);
    chk("R6", "irq cleared", rx_irq, 0);
    step("R6", 1, 8'h01, 0, 0, 0, 0, 0, 1);
    step("R6", 1, 8'h02, 0, 0, 0, 0, 0, 1);
    step("R7", 0, 0, 0, 0, 0, 1, 0, 0);
    chk("R7", "irq flushed", rx_irq, 0);

    for (int n = 0; n < 4000; n++) begin
      logic md;
      md = mmode;
      if (($urandom % 80) == 0) md = ~md;
      step("R10", ($urandom % 3) != 0, 8'($urandom), ($urandom % 5) == 0,
           ($urandom % 6) == 0, ($urandom % 17) == 0, ($urandom % 3) == 0,
           ($urandom % 11) == 0, md);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule